// File: doc/BRIEF.md
# Dual-Rail Word Completion Detector

This block watches a word of N dual-rail data bits and reports with one output when the whole word has arrived and when the whole word has been cleared again. Each bit travels on a pair of wires. One wire high carries a data value, and both wires low is the empty spacer that separates successive data items. The detector ORs the two wires of every bit into a presence flag. It then merges all presence flags through a tree of Muller C-elements, each of which holds its last output until all of its inputs agree.

The model is synchronous. Every C-element keeps its state in a register that updates on the rising clock edge, so the output settles a fixed number of cycles after the input, equal to the depth of the tree. The output has hysteresis. After it rises on a full word, it stays high while bits drop back to spacer one by one, and falls only when the last bit has cleared. Rising works the same way in the other direction. The detector is meant for a four-phase return-to-spacer data stream: the word fills up monotonically, then empties monotonically.

Top module: `dr_completion_top`

## Requirements
- R1: Bit i of the word sits on `rails[2i+1:2i]`. Rail pattern 00 is the spacer, and 01 or 10 is a valid value. Either rail alone makes the bit count as present.
- R2: When every bit holds a valid code, `done` becomes 1.
- R3: When every bit has returned to spacer, `done` becomes 0.
- R4: While some bits are present and others are spacer, `done` keeps its previous value, both on the way up and on the way down.
- R5: A change of the word takes effect on `done` after exactly DEPTH rising edges. DEPTH is the number of tree levels: ceil(log_RADIX N), and at least 1. The defaults N=8, RADIX=2 give a DEPTH of 3.
- R6: A synchronous active-high `rst` clears `done` and every internal C-element state to 0. `done` stays 0 while `rst` is held, whatever the input word.
- R7: A bit with both rails high (11) is counted as present. With STRICT_CODES=1, an assertion treats that code as a protocol violation.
- R8: RADIX may be 2 or 4. When N is not a multiple of the group size, a partly filled group still needs all of its real bits before it rises, and all of them cleared before it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rails | input | 2*N | Dual-rail word, two wires per bit |
| done | output | 1 | Registered completion flag with hysteresis |

## Verification
The bench builds two copies of the block. The first uses N=8 with two-input C-elements and STRICT_CODES=1. It gives a three-level tree, so the table of fill-and-drain sequences and the latency counts run through a full binary tree. The second uses N=5 with four-input C-elements and STRICT_CODES=0. It gives a two-level tree with a padded, partly filled group, and it lets the both-rails-high code be driven without tripping the legality assertion, so it can be shown to count as present.

// File: rtl/dr_completion_pkg.sv
package dr_completion_pkg;

  // Number of signals left after lv levels of RADIX-way merging
  function automatic int level_width(input int n, input int r, input int lv);
    int w;
    w = n;
    for (int i = 0; i < lv; i++) w = (w + r - 1) / r;
    return w;
  endfunction

  // Levels needed to merge n signals into one (at least one register level)
  function automatic int tree_depth(input int n, input int r);
    int w;
    int d;
    w = n;
    d = 0;
    while (w > 1) begin
      w = (w + r - 1) / r;
      d++;
    end
    if (d == 0) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/dr_presence.sv
module dr_presence #(
  parameter int N            = 8,
  parameter bit STRICT_CODES = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] rails,
  output logic [N-1:0]   present
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    // R1: either rail marks the bit present; R7: 11 also counts as present
    assign present[b] = rails[2*b] | rails[2*b+1];

    if (STRICT_CODES) begin : g_strict
      p_legal_code_r7 : assert property (@(posedge clk) disable iff (rst)
        !(rails[2*b] && rails[2*b+1]))
        else $error("bit %0d carries both rails high", b);
    end
  end

endmodule

// File: rtl/dr_celem.sv
module dr_celem #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in,
  output logic         q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (&in)     q <= 1'b1;
    else if (!(|in))  q <= 1'b0;
  end

  p_set_all_high_r2 : assert property (@(posedge clk) disable iff (rst)
    (&in) |=> q);

  p_clear_all_low_r3 : assert property (@(posedge clk) disable iff (rst)
    (!(|in)) |=> !q);

  p_hold_mixed_r4 : assert property (@(posedge clk) disable iff (rst)
    ((|in) && !(&in)) |=> $stable(q));

  p_reset_clears_r6 : assert property (@(posedge clk)
    rst |=> !q);

endmodule

// File: rtl/dr_ctree.sv
module dr_ctree
  import dr_completion_pkg::*;
#(
  parameter int N     = 8,
  parameter int RADIX = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] leaves,
  output logic         root
);

  localparam int DEPTH = tree_depth(N, RADIX);

  logic [DEPTH:0][N-1:0] stage;

  assign stage[0] = leaves;

  for (genvar lv = 0; lv < DEPTH; lv++) begin : g_level
    localparam int IN_CNT  = level_width(N, RADIX, lv);
    localparam int OUT_CNT = level_width(N, RADIX, lv + 1);

    for (genvar nd = 0; nd < N; nd++) begin : g_node
      if (nd < OUT_CNT) begin : g_used
        logic [RADIX-1:0] grp;
        for (genvar k = 0; k < RADIX; k++) begin : g_in
          localparam int SRC = nd * RADIX + k;
          // R8: missing inputs repeat a real one, which leaves the C rule unchanged
          if (SRC < IN_CNT) begin : g_real
            assign grp[k] = stage[lv][SRC];
          end else begin : g_pad
            assign grp[k] = stage[lv][nd * RADIX];
          end
        end
        dr_celem #(.W(RADIX)) u_c (
          .clk (clk),
          .rst (rst),
          .in  (grp),
          .q   (stage[lv+1][nd])
        );
      end else begin : g_idle
        assign stage[lv+1][nd] = 1'b0;
      end
    end
  end

  assign root = stage[DEPTH][0];

endmodule

// File: rtl/dr_completion_top.sv
module dr_completion_top #(
  parameter int N            = 8,
  parameter int RADIX        = 2,
  parameter bit STRICT_CODES = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] rails,
  output logic           done
);

  logic [N-1:0] present;

  initial begin
    assert (RADIX == 2 || RADIX == 4) else $error("RADIX must be 2 or 4 (R8)");
    assert (N >= 1) else $error("N must be positive");
  end

  dr_presence #(.N(N), .STRICT_CODES(STRICT_CODES)) u_pres (
    .clk     (clk),
    .rst     (rst),
    .rails   (rails),
    .present (present)
  );

  dr_ctree #(.N(N), .RADIX(RADIX)) u_tree (
    .clk    (clk),
    .rst    (rst),
    .leaves (present),
    .root   (done)
  );

  p_done_reset_r6 : assert property (@(posedge clk)
    rst |=> !done);

endmodule

// File: tb/dr_completion_top_test.sv
`timescale 1ns/1ps
module dr_completion_top_test;

  localparam int NA = 8;
  localparam int DA = 3;  // ceil(log2 8)
  localparam int NB = 5;
  localparam int DB = 2;  // ceil(log4 5)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NA-1:0] rails_a = '0;
  logic [2*NB-1:0] rails_b = '0;
  logic done_a;
  logic done_b;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  dr_completion_top #(.N(NA), .RADIX(2), .STRICT_CODES(1'b1)) uut (
    .clk (clk), .rst (rst), .rails (rails_a), .done (done_a)
  );

  dr_completion_top #(.N(NB), .RADIX(4), .STRICT_CODES(1'b0)) uut_b (
    .clk (clk), .rst (rst), .rails (rails_b), .done (done_b)
  );

  typedef struct packed {
    logic [2*NA-1:0] rails;
    logic            exp;
  } vec_t;

  // Monotonic fill / drain sequences; expectations from the all-or-nothing rule
  localparam vec_t VEC [15] = '{
    '{16'h0000, 1'b0},  // spacer
    '{16'h0001, 1'b0},  // R1 true rail of bit 0 only
    '{16'h0009, 1'b0},  // R4 partial fill
    '{16'h0999, 1'b0},  // R4 partial fill
    '{16'h9999, 1'b1},  // R2 full word, mixed values
    '{16'h9998, 1'b1},  // R4 drain begins
    '{16'h9900, 1'b1},  // R4
    '{16'h8000, 1'b1},  // R4 one bit left
    '{16'h0000, 1'b0},  // R3 drained
    '{16'h8000, 1'b0},  // R4 refill begins
    '{16'hAAAA, 1'b1},  // R1 R2 all false rails
    '{16'h2222, 1'b1},  // R4
    '{16'h0000, 1'b0},  // R3
    '{16'h5555, 1'b1},  // R1 R2 all true rails
    '{16'h0000, 1'b0}   // R3
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: done=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    // R6: reset state, with a full word held during reset
    @(negedge clk);
    rails_a = 16'h5555;
    rails_b = 10'h155;
    settle(5);
    chk("R6 reset holds done low (A)", done_a, 1'b0);
    chk("R6 reset holds done low (B)", done_b, 1'b0);
    rails_a = '0;
    rails_b = '0;
    settle(1);
    rst = 1'b0;
    settle(DA + 1);
    chk("R6 idle after reset (A)", done_a, 1'b0);

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 15; i++) begin
      rails_a = VEC[i].rails;
      settle(DA + 1);
      chk($sformatf("R2 R3 R4 table step %0d", i), done_a, VEC[i].exp);
    end

    // R5: rise latency
    rails_a = 16'h5555;
    settle(DA - 1);
    chk("R5 rise not before depth", done_a, 1'b0);
    settle(1);
    chk("R5 rise at depth", done_a, 1'b1);

    // R6: reset while done is high, input stays full
    rst = 1'b1;
    settle(1);
    chk("R6 reset clears done", done_a, 1'b0);
    rst = 1'b0;
    settle(DA - 1);
    chk("R6 state cleared, no early rise", done_a, 1'b0);
    settle(1);
    chk("R5 rise again after reset", done_a, 1'b1);

    // R4 hold on partial drain, then R5 fall latency
    rails_a = 16'h0001;
    settle(DA + 3);
    chk("R4 partial drain holds", done_a, 1'b1);
    rails_a = 16'h0000;
    settle(DA - 1);
    chk("R5 fall not before depth", done_a, 1'b1);
    settle(1);
    chk("R3 fall at depth", done_a, 1'b0);

    // R8: padded group on the 4-way tree, only the lone bit present
    rails_b = 10'h100;
    settle(DB + 2);
    chk("R8 lone padded bit does not complete", done_b, 1'b0);
    // R7: bit 4 carries 11, others valid
    rails_b = 10'h355;
    settle(DB - 1);
    chk("R5 R8 no early rise (B)", done_b, 1'b0);
    settle(1);
    chk("R7 both-rails code counts as present", done_b, 1'b1);
    // R4 R8: drain to only the padded-group bit
    rails_b = 10'h300;
    settle(DB + 2);
    chk("R4 R8 hold with padded bit left", done_b, 1'b1);
    rails_b = 10'h000;
    settle(DB - 1);
    chk("R8 no early fall (B)", done_b, 1'b1);
    settle(1);
    chk("R3 fall on B", done_b, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule